// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block supplies the fetch stage with a next-PC guess in the same cycle as the fetch address arrives. A small direct-mapped table records branches that were seen to go taken. For each one it keeps the upper address bits and the destination. A fetch address whose slot is valid and whose full upper bits match is redirected to the stored destination. Every other fetch address falls through to the sequential word, PC+4. Only taken branches are ever stored, so a hit means the branch is predicted taken.

A later pipeline stage reports each resolved branch on a resolve port. The report carries the branch address, the real direction, the real destination and the next PC that fetch had used. The table is then updated. A taken branch that was absent is inserted, and a taken branch with a stale destination has it rewritten. A branch that hit but fell through is removed. When the real next PC differs from the one fetch used, a one-cycle flush pulse carries the correct restart address.

Top module: `btb_direct`

## Requirements
- R1: After reset no entry is valid, so every fetch address misses (`fetch_hit` = 0) and `fetch_next_pc` = `fetch_pc` + 4.
- R2: The slot is chosen by `fetch_pc[IDX_W+1:2]`, and the remaining upper bits `fetch_pc[PC_W-1:IDX_W+2]` must match the stored bits exactly for a hit. An address that differs only in any upper bit misses.
- R3: On a hit `fetch_next_pc` is the stored destination. On a miss it is `fetch_pc` + 4. Both are combinational in the same cycle.
- R4: A valid resolve with `rs_taken` = 1 for a branch not in the table writes its address and `rs_target`, and lookups of that address hit from the next cycle on.
- R5: A valid resolve with `rs_taken` = 0 for a branch present in the table removes it, so lookups of that address miss from the next cycle on.
- R6: A valid taken resolve for a present branch whose stored destination differs from `rs_target` replaces the destination with `rs_target`.
- R7: One cycle after a valid resolve, `flush` is 1 for exactly that cycle when the real next PC differs from `rs_pred_npc`. The real next PC is `rs_target` if taken, else `rs_pc` + 4. `flush_pc` then holds the real next PC. Otherwise `flush` is 0.
- R8: When a resolve writes or removes the slot that a fetch reads in the same cycle, the fetch sees the contents from before the update.
- R9: A taken branch inserted into a slot held by a different branch replaces it, and the old branch then misses.
- R10: With `rs_valid` = 0 the table and `flush` are unaffected, whatever the other resolve inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_hit | output | 1 | Lookup found a matching valid entry |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real direction of the resolved branch |
| rs_target | input | PC_W | Real destination of the resolved branch |
| rs_pred_npc | input | PC_W | Next PC that fetch used after this branch |
| flush | output | 1 | One-cycle mispredict pulse |
| flush_pc | output | PC_W | Correct restart address while `flush` is 1 |

## Verification
The hardest case to reach from the ports is a resolve and a fetch that land on the same slot in the same cycle. It matters most when the resolve changes that slot, either by writing it or by evicting a different branch that shares it. The stimulus schedules directed steps in which the fetch address equals the resolving address, or differs from it only in its upper bits. It then checks the lookup in that cycle and again in the next one. A long random phase draws addresses from a pool wider than the table, so that aliasing, removal and destination rewrites occur often alongside correct predictions.

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic [PC_W-1:0] rs_pred_npc,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag;
  logic             r_hit, wr_en, kill;
  logic [PC_W-1:0]  r_actual;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign r_idx = rs_pc[IDX_W+1:2];
  assign r_tag = rs_pc[PC_W-1:IDX_W+2];

  assign fetch_hit     = valid_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign fetch_next_pc = fetch_hit ? tgt_q[f_idx] : fetch_pc + PC_W'(4);

  assign r_hit    = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign r_actual = rs_taken ? rs_target : rs_pc + PC_W'(4);
  assign wr_en    = rs_valid && rs_taken && !(r_hit && tgt_q[r_idx] == rs_target);
  assign kill     = rs_valid && !rs_taken && r_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[r_idx] <= 1'b1;
    else if (kill)  valid_q[r_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[r_idx] <= r_tag;
      tgt_q[r_idx] <= rs_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush    <= 1'b0;
      flush_pc <= '0;
    end else begin
      flush    <= rs_valid && (r_actual != rs_pred_npc);
      flush_pc <= r_actual;
    end
  end
endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_hit,
  input logic [PC_W-1:0] fetch_next_pc,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_taken,
  input logic [PC_W-1:0] rs_target,
  input logic [PC_W-1:0] rs_pred_npc,
  input logic            flush,
  input logic [PC_W-1:0] flush_pc
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fetch_hit);

  assert_insert_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=>
      (fetch_pc != $past(rs_pc) || (fetch_hit && fetch_next_pc == $past(rs_target))));

  assert_remove_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken) |=> (fetch_pc != $past(rs_pc) || !fetch_hit));

  assert_flush_on_mispredict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && rs_target != rs_pred_npc) |=> (flush && flush_pc == $past(rs_target)));

  assert_idle_no_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> !flush);
endmodule

bind btb_direct btb_direct_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
  .fetch_next_pc(fetch_next_pc), .rs_valid(rs_valid), .rs_pc(rs_pc),
  .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_npc(rs_pred_npc),
  .flush(flush), .flush_pc(flush_pc)
);

// File: tb/btb_direct_tb.sv
module btb_direct_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int ENTRIES = 16;

  logic clk = 0, rst_n = 0;
  logic [31:0] fetch_pc = 0, rs_pc = 0, rs_target = 0, rs_pred_npc = 0;
  logic rs_valid = 0, rs_taken = 0;
  logic fetch_hit, flush;
  logic [31:0] fetch_next_pc, flush_pc;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] m_pc [int];
  logic [31:0] m_tgt [int];
  logic exp_flush = 0;
  logic [31:0] exp_fpc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_direct #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_next_pc(fetch_next_pc), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_npc(rs_pred_npc),
    .flush(flush), .flush_pc(flush_pc));

  function automatic int slot(input logic [31:0] a);
    return int'((a >> 2) % ENTRIES);
  endfunction

  function automatic logic m_hit(input logic [31:0] a);
    return m_pc.exists(slot(a)) && (m_pc[slot(a)][31:2] == a[31:2]);
  endfunction

  function automatic logic [31:0] m_npc(input logic [31:0] a);
    return m_hit(a) ? m_tgt[slot(a)] : a + 32'd4;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [31:0] fpc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input logic [31:0] rtg,
                      input logic [31:0] rpred);
    logic [31:0] actual;
    @(negedge clk);
    fetch_pc = fpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg; rs_pred_npc = rpred;
    #1;
    chk(req, "fetch_hit", {31'd0, fetch_hit}, {31'd0, m_hit(fpc)});
    chk(req, "fetch_next_pc", fetch_next_pc, m_npc(fpc));
    chk("R7", "flush", {31'd0, flush}, {31'd0, exp_flush});
    if (exp_flush) chk("R7", "flush_pc", flush_pc, exp_fpc);
    @(posedge clk);
    actual = rt ? rtg : rpc + 32'd4;
    exp_flush = rv && (actual != rpred);
    exp_fpc = actual;
    if (rv) begin
      if (rt) begin
        m_pc[slot(rpc)] = rpc;
        m_tgt[slot(rpc)] = rtg;
      end else if (m_hit(rpc)) begin
        m_pc.delete(slot(rpc));
        m_tgt.delete(slot(rpc));
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0000_1000;
  localparam logic [31:0] B = 32'h0000_1008;
  localparam logic [31:0] C = 32'h0000_2010;
  localparam logic [31:0] D = C + 32'(ENTRIES * 4);

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step("R1", A, 0, 0, 0, 0, 0);
    step("R1", B, 0, 0, 0, 0, 0);
    step("R1", 32'hFFFF_FFFC, 0, 0, 0, 0, 0);
    step("R4", A, 1, A, 1, 32'h0000_4000, A + 4);
    step("R3", A, 0, 0, 0, 0, 0);
    step("R8", B, 1, B, 1, 32'h0000_5000, B + 4);
    step("R4", B, 0, 0, 0, 0, 0);
    step("R6", A, 1, A, 1, 32'h0000_4400, 32'h0000_4000);
    step("R6", A, 0, 0, 0, 0, 0);
    step("R5", A, 1, A, 0, 0, 32'h0000_4400);
    step("R5", A, 0, 0, 0, 0, 0);
    step("R9", C, 1, C, 1, 32'h0000_6000, C + 4);
    step("R8", D, 1, D, 1, 32'h0000_7000, D + 4);
    step("R9", C, 0, 0, 0, 0, 0);
    step("R9", D, 0, 0, 0, 0, 0);
    step("R2", D ^ 32'h8000_0000, 0, 0, 0, 0, 0);
    step("R2", D ^ 32'h0000_0400, 0, 0, 0, 0, 0);
    step("R7", D, 1, D, 1, 32'h0000_7000, 32'h0000_7000);
    step("R10", D, 1, B, 0, 0, 32'h0000_5000);
    step("R10", B, 0, D, 0, 32'h1234_5678, 32'h0);
    step("R10", D, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] f, r, t, p;
      logic tk, v;
      f = 32'h0000_1000 + 32'(4 * ($urandom % 40));
      r = ($urandom % 4 == 0) ? f : 32'h0000_1000 + 32'(4 * ($urandom % 40));
      tk = ($urandom % 3) != 0;
      t = 32'h0000_8000 + 32'(4 * ($urandom % 3));
      p = ($urandom % 4 == 0) ? r + 32'd4 : m_npc(r);
      v = ($urandom % 5) != 0;
      step("R3", f, v, r, tk, t, p);
    end
    step("R7", A, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule